// File: doc/BRIEF.md
# Task Dependence Tracking Engine

The engine keeps the dependence graph of in-flight tasks so that a scheduler running in software only has to pick among tasks that are already runnable. Software names each task and each data dependence by a small internal ID. It creates a task with its descriptor address, then declares the task's dependences one at a time as inputs or outputs. From these declarations the engine derives read-after-write, write-after-read and write-after-write edges. It does this by keeping, for every dependence, its last writer and its current set of readers. The graph edges are held apart from this, as successor sets per task.

When software reports that a task has finished, the engine lowers the predecessor count of each successor. A successor whose count reaches zero goes into a ready FIFO. The finished task is then taken out of the writer and reader state of its dependences, and its entry is released. A get-ready command pops the FIFO and returns the descriptor address and successor count of the popped task. Commands run strictly one after another, and the engine holds off new commands with a ready handshake while a command is still being processed.

Top module: `tdep_engine`

## Requirements
- R1: After reset, `cmd_ready` is high and `rsp_valid` is low.
- R2: A create command (op 0) stores the descriptor address for the task ID and clears its successor and predecessor counts, its successor set and its dependence set. Reusing the ID of a finished task yields a fresh task.
- R3: Declaring an input dependence (op 1, `cmd_out`=0) on a dependence that has a valid last writer adds an edge from that writer to the task. The task is also added to that dependence's readers.
- R4: Declaring an output dependence (`cmd_out`=1) adds an edge from the valid last writer and from every current reader to the task. The reader set is then emptied, and the task becomes the valid last writer.
- R5: Each edge counts once. A second edge between the same pair of tasks, or an edge from a task to itself, changes no count.
- R6: A finish command (op 2) decrements the predecessor count of every successor whose count is non-zero. Successors that reach zero and are sealed enter the ready FIFO in ascending task-ID order.
- R7: An add command with `cmd_last`=1 seals the task, and pushes it at once if its predecessor count is zero. A task that is not sealed is never pushed.
- R8: A finish command removes the task from the reader set of each of its dependences, and clears the last writer where that writer is this task. A dependence left with no writer and no readers is free, and a later accessor gets no edge from it.
- R9: A get command (op 3) raises `rsp_valid` for one cycle, one cycle after acceptance. On an empty FIFO it returns a zero descriptor and a zero count. Otherwise it returns, in FIFO order, the descriptor and current successor count of the popped task.
- R10: Commands are handled one at a time. After acceptance, `cmd_ready` stays low for 0 cycles for create and get, 2 for an input add, NTASK+2 for an output add, and NTASK+NDEP for finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; command accepted when both high |
| cmd_op | input | 2 | 0 create, 1 add dependence, 2 finish, 3 get ready |
| cmd_task | input | $clog2(NTASK) | Task ID |
| cmd_dep | input | $clog2(NDEP) | Dependence ID (add only) |
| cmd_out | input | 1 | 1 output dependence, 0 input (add only) |
| cmd_last | input | 1 | Last dependence of the task (add only) |
| cmd_desc | input | ADDR_W | Descriptor address (create only) |
| rsp_valid | output | 1 | Get-ready response pulse |
| rsp_desc | output | ADDR_W | Descriptor of ready task, zero if none |
| rsp_nsucc | output | $clog2(NTASK+1) | Successor count of ready task |

## Verification
The graph is driven through a plain read-after-write chain, readers followed by an overwriting writer (war and waw fan-in), duplicate edges reached through two dependences, and a task that both reads and writes one dependence. These show whether edges are counted per pair or per declaration, and whether self-edges are dropped. Separate sequences finish a predecessor before its successor is sealed, free a dependence and touch it again, and reuse a finished task ID. These separate a correct wakeup from early or stale releases. A behavioural queue model predicts every get response, and the idle time after every command is compared with the per-command cycle counts.

// File: rtl/tdep_pkg.sv
package tdep_pkg;
  typedef enum logic [1:0] {
    OP_CREATE = 2'd0,
    OP_ADD    = 2'd1,
    OP_FINISH = 2'd2,
    OP_GET    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADD_WR,
    S_ADD_RD,
    S_ADD_END,
    S_FIN_SUCC,
    S_FIN_DEP
  } st_e;
endpackage

// File: rtl/tdep_ready_fifo.sv
module tdep_ready_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) begin
      wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    end
    if (pop) begin
      rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    end
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wp_q == PW'(i)) mem_q[i] <= push_data;
    end
  end

  assign head  = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tdep_task_table.sv
module tdep_task_table #(
  parameter int NTASK  = 16,
  parameter int NDEP   = 16,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       create_en,
  input  logic [$clog2(NTASK)-1:0]   create_id,
  input  logic [ADDR_W-1:0]          create_desc,
  input  logic                       edge_en,
  input  logic [$clog2(NTASK)-1:0]   edge_from,
  input  logic [$clog2(NTASK)-1:0]   edge_to,
  input  logic                       mark_en,
  input  logic [$clog2(NTASK)-1:0]   mark_task,
  input  logic [$clog2(NDEP)-1:0]    mark_dep,
  input  logic                       seal_en,
  input  logic [$clog2(NTASK)-1:0]   seal_id,
  input  logic                       dec_en,
  input  logic [$clog2(NTASK)-1:0]   dec_id,
  input  logic                       free_en,
  input  logic [$clog2(NTASK)-1:0]   free_id,
  input  logic [$clog2(NTASK)-1:0]   a_id,
  output logic [ADDR_W-1:0]          a_desc,
  output logic [$clog2(NTASK+1)-1:0] a_nsucc,
  output logic [$clog2(NTASK+1)-1:0] a_pred,
  output logic [NTASK-1:0]           a_succ_row,
  output logic [NDEP-1:0]            a_dep_row,
  input  logic [$clog2(NTASK)-1:0]   b_id,
  output logic [$clog2(NTASK+1)-1:0] b_pred,
  output logic                       b_valid,
  output logic                       b_sealed
);
  localparam int TID_W = $clog2(NTASK);
  localparam int CNT_W = $clog2(NTASK + 1);

  logic [ADDR_W-1:0] desc_q  [NTASK];
  logic [ADDR_W-1:0] desc_d  [NTASK];
  logic [CNT_W-1:0]  nsucc_q [NTASK];
  logic [CNT_W-1:0]  nsucc_d [NTASK];
  logic [CNT_W-1:0]  pred_q  [NTASK];
  logic [CNT_W-1:0]  pred_d  [NTASK];
  logic [NTASK-1:0]  succ_q  [NTASK];
  logic [NTASK-1:0]  succ_d  [NTASK];
  logic [NDEP-1:0]   deps_q  [NTASK];
  logic [NDEP-1:0]   deps_d  [NTASK];
  logic [NTASK-1:0]  valid_q, valid_d, sealed_q, sealed_d, en;
  logic [NTASK-1:0]  hc, hf, hes, hed, hm, hs, hd;
  logic              edge_ok;

  always_comb begin
    edge_ok = edge_en && (edge_from != edge_to) && !succ_q[edge_from][edge_to];
    for (int i = 0; i < NTASK; i++) begin
      hc[i]  = create_en && (create_id == TID_W'(i));
      hf[i]  = free_en   && (free_id   == TID_W'(i));
      hes[i] = edge_ok   && (edge_from == TID_W'(i));
      hed[i] = edge_ok   && (edge_to   == TID_W'(i));
      hm[i]  = mark_en   && (mark_task == TID_W'(i));
      hs[i]  = seal_en   && (seal_id   == TID_W'(i));
      hd[i]  = dec_en    && (dec_id    == TID_W'(i));
      en[i]  = hc[i] | hf[i] | hes[i] | hed[i] | hm[i] | hs[i] | hd[i];

      desc_d[i]   = hc[i] ? create_desc : desc_q[i];
      nsucc_d[i]  = nsucc_q[i];
      pred_d[i]   = pred_q[i];
      succ_d[i]   = succ_q[i];
      deps_d[i]   = deps_q[i];
      valid_d[i]  = valid_q[i];
      sealed_d[i] = sealed_q[i];
      if (hc[i] || hf[i]) begin
        nsucc_d[i]  = '0;
        succ_d[i]   = '0;
        deps_d[i]   = '0;
        valid_d[i]  = hc[i];
        sealed_d[i] = 1'b0;
        if (hc[i]) pred_d[i] = '0;
      end else begin
        if (hes[i]) begin
          nsucc_d[i]           = nsucc_q[i] + CNT_W'(1);
          succ_d[i][edge_to]   = 1'b1;
        end
        if (hed[i]) pred_d[i] = pred_q[i] + CNT_W'(1);
        if (hd[i])  pred_d[i] = pred_q[i] - CNT_W'(1);
        if (hm[i])  deps_d[i][mark_dep] = 1'b1;
        if (hs[i])  sealed_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= '0;
      sealed_q <= '0;
      for (int i = 0; i < NTASK; i++) begin
        desc_q[i]  <= '0;
        nsucc_q[i] <= '0;
        pred_q[i]  <= '0;
        succ_q[i]  <= '0;
        deps_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NTASK; i++) begin
        if (en[i]) begin
          desc_q[i]   <= desc_d[i];
          nsucc_q[i]  <= nsucc_d[i];
          pred_q[i]   <= pred_d[i];
          succ_q[i]   <= succ_d[i];
          deps_q[i]   <= deps_d[i];
          valid_q[i]  <= valid_d[i];
          sealed_q[i] <= sealed_d[i];
        end
      end
    end
  end

  assign a_desc     = desc_q[a_id];
  assign a_nsucc    = nsucc_q[a_id];
  assign a_pred     = pred_q[a_id];
  assign a_succ_row = succ_q[a_id];
  assign a_dep_row  = deps_q[a_id];
  assign b_pred     = pred_q[b_id];
  assign b_valid    = valid_q[b_id];
  assign b_sealed   = sealed_q[b_id];

  p_dec_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (pred_q[dec_id] != '0));
endmodule

// File: rtl/tdep_dep_table.sv
module tdep_dep_table #(
  parameter int NTASK = 16,
  parameter int NDEP  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NDEP)-1:0]  op_dep,
  input  logic [$clog2(NTASK)-1:0] op_task,
  input  logic                     rd_add_en,
  input  logic                     wr_set_en,
  input  logic                     drop_en,
  input  logic [$clog2(NDEP)-1:0]  q_dep,
  output logic                     q_wrv,
  output logic [$clog2(NTASK)-1:0] q_wr,
  output logic [NTASK-1:0]         q_readers
);
  localparam int TID_W = $clog2(NTASK);
  localparam int DID_W = $clog2(NDEP);

  logic [TID_W-1:0] wr_q  [NDEP];
  logic [TID_W-1:0] wr_d  [NDEP];
  logic [NTASK-1:0] rdr_q [NDEP];
  logic [NTASK-1:0] rdr_d [NDEP];
  logic [NDEP-1:0]  wrv_q, wrv_d, en;

  always_comb begin
    for (int j = 0; j < NDEP; j++) begin
      en[j]    = (rd_add_en || wr_set_en || drop_en) && (op_dep == DID_W'(j));
      wr_d[j]  = wr_q[j];
      wrv_d[j] = wrv_q[j];
      rdr_d[j] = rdr_q[j];
      if (wr_set_en) begin
        rdr_d[j] = '0;
        wr_d[j]  = op_task;
        wrv_d[j] = 1'b1;
      end else if (rd_add_en) begin
        rdr_d[j][op_task] = 1'b1;
      end else if (drop_en) begin
        rdr_d[j][op_task] = 1'b0;
        if (wr_q[j] == op_task) wrv_d[j] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrv_q <= '0;
      for (int j = 0; j < NDEP; j++) begin
        wr_q[j]  <= '0;
        rdr_q[j] <= '0;
      end
    end else begin
      for (int j = 0; j < NDEP; j++) begin
        if (en[j]) begin
          wr_q[j]  <= wr_d[j];
          wrv_q[j] <= wrv_d[j];
          rdr_q[j] <= rdr_d[j];
        end
      end
    end
  end

  assign q_wrv     = wrv_q[q_dep];
  assign q_wr      = wr_q[q_dep];
  assign q_readers = rdr_q[q_dep];

  p_one_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_add_en, wr_set_en, drop_en}) <= 1);
endmodule

// File: rtl/tdep_engine.sv
module tdep_engine
  import tdep_pkg::*;
#(
  parameter int NTASK  = 16,
  parameter int NDEP   = 16,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(NTASK)-1:0]   cmd_task,
  input  logic [$clog2(NDEP)-1:0]    cmd_dep,
  input  logic                       cmd_out,
  input  logic                       cmd_last,
  input  logic [ADDR_W-1:0]          cmd_desc,
  output logic                       rsp_valid,
  output logic [ADDR_W-1:0]          rsp_desc,
  output logic [$clog2(NTASK+1)-1:0] rsp_nsucc
);
  localparam int TID_W = $clog2(NTASK);
  localparam int DID_W = $clog2(NDEP);
  localparam int CNT_W = $clog2(NTASK + 1);
  localparam int IDX_W = (TID_W > DID_W) ? TID_W : DID_W;

  st_e              state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TID_W-1:0] cur_task_q;
  logic [DID_W-1:0] cur_dep_q;
  logic             cur_out_q, cur_last_q;
  op_e              op;
  logic             accept, get_acc;

  logic             create_en, edge_en, mark_en, seal_en, dec_en, free_en;
  logic [TID_W-1:0] edge_from, a_id;
  logic [ADDR_W-1:0] a_desc;
  logic [CNT_W-1:0] a_nsucc, a_pred, b_pred;
  logic [NTASK-1:0] a_succ_row;
  logic [NDEP-1:0]  a_dep_row;
  logic             b_valid, b_sealed;

  logic             rd_add_en, wr_set_en, drop_en;
  logic [DID_W-1:0] op_dep;
  logic             q_wrv;
  logic [TID_W-1:0] q_wr;
  logic [NTASK-1:0] q_readers;

  logic             push, pop, fifo_empty, fifo_full;
  logic [TID_W-1:0] push_data, fifo_head;
  logic             task_last, dep_last;
  logic [TID_W-1:0] idx_t;
  logic [DID_W-1:0] idx_d_sl;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (state_q == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign get_acc   = accept && (op == OP_GET);
  assign idx_t     = idx_q[TID_W-1:0];
  assign idx_d_sl  = idx_q[DID_W-1:0];
  assign task_last = (idx_q == IDX_W'(NTASK - 1));
  assign dep_last  = (idx_q == IDX_W'(NDEP - 1));
  assign a_id      = (state_q == S_IDLE) ? fifo_head : cur_task_q;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    create_en = 1'b0;
    edge_en   = 1'b0;
    edge_from = q_wr;
    mark_en   = 1'b0;
    seal_en   = 1'b0;
    dec_en    = 1'b0;
    free_en   = 1'b0;
    rd_add_en = 1'b0;
    wr_set_en = 1'b0;
    drop_en   = 1'b0;
    op_dep    = cur_dep_q;
    push      = 1'b0;
    push_data = cur_task_q;
    pop       = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          case (op)
            OP_CREATE: create_en = 1'b1;
            OP_ADD:    state_d   = S_ADD_WR;
            OP_FINISH: begin
              state_d = S_FIN_SUCC;
              idx_d   = '0;
            end
            default:   pop = !fifo_empty;
          endcase
        end
      end
      S_ADD_WR: begin
        mark_en   = 1'b1;
        edge_en   = q_wrv;
        rd_add_en = !cur_out_q;
        idx_d     = '0;
        state_d   = cur_out_q ? S_ADD_RD : S_ADD_END;
      end
      S_ADD_RD: begin
        edge_from = idx_t;
        edge_en   = q_readers[idx_t];
        idx_d     = idx_q + IDX_W'(1);
        if (task_last) begin
          wr_set_en = 1'b1;
          state_d   = S_ADD_END;
        end
      end
      S_ADD_END: begin
        seal_en = cur_last_q;
        push    = cur_last_q && (a_pred == '0);
        state_d = S_IDLE;
      end
      S_FIN_SUCC: begin
        dec_en    = a_succ_row[idx_t] && b_valid && (b_pred != '0);
        push      = dec_en && (b_pred == CNT_W'(1)) && b_sealed;
        push_data = idx_t;
        idx_d     = idx_q + IDX_W'(1);
        if (task_last) begin
          idx_d   = '0;
          state_d = S_FIN_DEP;
        end
      end
      S_FIN_DEP: begin
        op_dep  = idx_d_sl;
        drop_en = a_dep_row[idx_d_sl];
        idx_d   = idx_q + IDX_W'(1);
        if (dep_last) begin
          free_en = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_task_q <= '0;
      cur_dep_q  <= '0;
      cur_out_q  <= 1'b0;
      cur_last_q <= 1'b0;
    end else if (accept) begin
      cur_task_q <= cmd_task;
      cur_dep_q  <= cmd_dep;
      cur_out_q  <= cmd_out;
      cur_last_q <= cmd_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_desc  <= '0;
      rsp_nsucc <= '0;
    end else begin
      rsp_valid <= get_acc;
      if (get_acc) begin
        rsp_desc  <= fifo_empty ? '0 : a_desc;
        rsp_nsucc <= fifo_empty ? '0 : a_nsucc;
      end
    end
  end

  tdep_task_table #(.NTASK(NTASK), .NDEP(NDEP), .ADDR_W(ADDR_W)) u_tasks (
    .clk, .rst_n,
    .create_en, .create_id(cmd_task), .create_desc(cmd_desc),
    .edge_en, .edge_from, .edge_to(cur_task_q),
    .mark_en, .mark_task(cur_task_q), .mark_dep(cur_dep_q),
    .seal_en, .seal_id(cur_task_q),
    .dec_en, .dec_id(idx_t),
    .free_en, .free_id(cur_task_q),
    .a_id, .a_desc, .a_nsucc, .a_pred, .a_succ_row, .a_dep_row,
    .b_id(idx_t), .b_pred, .b_valid, .b_sealed
  );

  tdep_dep_table #(.NTASK(NTASK), .NDEP(NDEP)) u_deps (
    .clk, .rst_n,
    .op_dep, .op_task(cur_task_q),
    .rd_add_en, .wr_set_en, .drop_en,
    .q_dep(cur_dep_q), .q_wrv, .q_wr, .q_readers
  );

  tdep_ready_fifo #(.DEPTH(NTASK), .W(TID_W)) u_rq (
    .clk, .rst_n,
    .push, .push_data, .pop,
    .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  p_rsp_after_get_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(cmd_valid && cmd_ready && cmd_op == 2'd3));
  p_add_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd1) |=> !cmd_ready);
  p_fin_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> !cmd_ready);
endmodule

// File: tb/tdep_engine_tb.sv
module tdep_engine_tb;
  localparam int NTASK  = 16;
  localparam int NDEP   = 16;
  localparam int ADDR_W = 32;
  localparam int TID_W  = $clog2(NTASK);
  localparam int DID_W  = $clog2(NDEP);
  localparam int CNT_W  = $clog2(NTASK + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [1:0]        cmd_op;
  logic [TID_W-1:0]  cmd_task;
  logic [DID_W-1:0]  cmd_dep;
  logic              cmd_out;
  logic              cmd_last;
  logic [ADDR_W-1:0] cmd_desc;
  logic              rsp_valid;
  logic [ADDR_W-1:0] rsp_desc;
  logic [CNT_W-1:0]  rsp_nsucc;

  always #4 clk = ~clk;

  tdep_engine #(.NTASK(NTASK), .NDEP(NDEP), .ADDR_W(ADDR_W)) u_dut (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_task, .cmd_dep,
    .cmd_out, .cmd_last, .cmd_desc, .rsp_valid, .rsp_desc, .rsp_nsucc
  );

  int n_run = 0;
  int n_fail = 0;
  int rsp_seen = 0;
  int gets = 0;
  bit done = 0;

  logic [ADDR_W-1:0] m_desc [NTASK];
  int  m_scnt [NTASK];
  int  m_pred [NTASK];
  bit  m_valid [NTASK];
  bit  m_sealed [NTASK];
  bit  m_succ [NTASK][NTASK];
  bit  m_deps [NTASK][NDEP];
  int  m_wr [NDEP];
  bit  m_wrv [NDEP];
  bit  m_rdr [NDEP][NTASK];
  int  rq [$];

  task automatic check(input string tag, input bit ok, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void m_edge(int f, int t);
    if (f != t && !m_succ[f][t]) begin
      m_succ[f][t] = 1;
      m_scnt[f]++;
      m_pred[t]++;
    end
  endfunction

  task automatic cmd(input int op, input int t, input int d, input bit o,
                     input bit l, input logic [ADDR_W-1:0] desc, input string tag);
    int busy;
    int exp_busy;
    logic [ADDR_W-1:0] ed;
    int en;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = 2'(op); cmd_task = TID_W'(t); cmd_dep = DID_W'(d);
    cmd_out = o; cmd_last = l; cmd_desc = desc; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3) begin
      gets++;
      if (rq.size() == 0) begin ed = '0; en = 0; end
      else begin
        int id = rq.pop_front();
        ed = m_desc[id]; en = m_scnt[id];
      end
      check({tag, " R9 rsp_valid"}, rsp_valid == 1'b1, rsp_valid, 1);
      check({tag, " desc"}, rsp_desc == ed, rsp_desc, ed);
      check({tag, " nsucc"}, rsp_nsucc == CNT_W'(en), rsp_nsucc, en);
    end
    busy = 0;
    while (!cmd_ready && busy < 1000) begin busy++; @(negedge clk); end
    exp_busy = (op == 1) ? (o ? NTASK + 2 : 2) : (op == 2) ? NTASK + NDEP : 0;
    check("R10 busy cycles", busy == exp_busy, busy, exp_busy);
    case (op)
      0: begin
        m_desc[t] = desc; m_scnt[t] = 0; m_pred[t] = 0; m_valid[t] = 1; m_sealed[t] = 0;
        for (int i = 0; i < NTASK; i++) m_succ[t][i] = 0;
        for (int j = 0; j < NDEP; j++) m_deps[t][j] = 0;
      end
      1: begin
        m_deps[t][d] = 1;
        if (m_wrv[d]) m_edge(m_wr[d], t);
        if (!o) m_rdr[d][t] = 1;
        else begin
          for (int i = 0; i < NTASK; i++) begin
            if (m_rdr[d][i]) m_edge(i, t);
            m_rdr[d][i] = 0;
          end
          m_wr[d] = t; m_wrv[d] = 1;
        end
        if (l) begin
          m_sealed[t] = 1;
          if (m_pred[t] == 0) rq.push_back(t);
        end
      end
      2: begin
        for (int i = 0; i < NTASK; i++) begin
          if (m_succ[t][i] && m_valid[i] && m_pred[i] > 0) begin
            m_pred[i]--;
            if (m_pred[i] == 0 && m_sealed[i]) rq.push_back(i);
          end
        end
        for (int j = 0; j < NDEP; j++) begin
          if (m_deps[t][j]) begin
            m_rdr[j][t] = 0;
            if (m_wrv[j] && m_wr[j] == t) m_wrv[j] = 0;
          end
        end
        m_valid[t] = 0; m_scnt[t] = 0;
        for (int i = 0; i < NTASK; i++) m_succ[t][i] = 0;
        for (int j = 0; j < NDEP; j++) m_deps[t][j] = 0;
      end
      default: ;
    endcase
  endtask

  task automatic create(input int t, input logic [ADDR_W-1:0] desc);
    cmd(0, t, 0, 0, 0, desc, "R2 create");
  endtask
  task automatic add(input int t, input int d, input bit o, input bit l);
    cmd(1, t, d, o, l, '0, "add");
  endtask
  task automatic fin(input int t);
    cmd(2, t, 0, 0, 0, '0, "finish");
  endtask
  task automatic get(input string tag);
    cmd(3, 0, 0, 0, 0, '0, tag);
  endtask

  always @(negedge clk) if (rst_n === 1'b1 && rsp_valid === 1'b1) rsp_seen++;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NTASK; i++) begin
      m_desc[i] = '0; m_scnt[i] = 0; m_pred[i] = 0; m_valid[i] = 0; m_sealed[i] = 0;
      for (int k = 0; k < NTASK; k++) m_succ[i][k] = 0;
      for (int j = 0; j < NDEP; j++) m_deps[i][j] = 0;
    end
    for (int j = 0; j < NDEP; j++) begin
      m_wr[j] = 0; m_wrv[j] = 0;
      for (int i = 0; i < NTASK; i++) m_rdr[j][i] = 0;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_task = '0; cmd_dep = '0;
    cmd_out = 1'b0; cmd_last = 1'b0; cmd_desc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", cmd_ready == 1'b1, cmd_ready, 1);
    check("R1 no response after reset", rsp_valid == 1'b0, rsp_valid, 0);
    get("R9 empty fifo null");

    create(1, 32'h0000_1000); create(2, 32'h0000_2000);
    create(3, 32'h0000_3000); create(4, 32'h0000_4000);
    add(1, 0, 1, 1);
    add(2, 0, 0, 1);
    add(3, 0, 0, 0); add(3, 1, 1, 1);
    add(4, 0, 1, 1);
    get("R3 R4 writer with three successors");
    get("R9 null after drain");
    fin(1);
    get("R6 first woken in id order");
    get("R6 second woken in id order");
    fin(2);
    get("R6 partial decrement keeps task");
    fin(3);
    get("R6 last predecessor wakes writer");

    create(5, 32'h0000_5000); create(6, 32'h0000_6000);
    add(5, 2, 0, 0); add(5, 3, 1, 1);
    add(6, 2, 1, 0); add(6, 3, 0, 1);
    get("R5 duplicate edge counted once");
    fin(5);
    get("R5 single predecessor release");
    create(7, 32'h0000_7000);
    add(7, 4, 0, 0); add(7, 4, 1, 1);
    get("R5 no self edge");

    create(8, 32'h0000_8000); create(9, 32'h0000_9000);
    add(8, 5, 1, 1);
    get("R7 sealed zero-pred pushed");
    add(9, 5, 0, 0);
    fin(8);
    get("R7 unsealed not pushed");
    add(9, 6, 0, 1);
    get("R7 push on seal");

    fin(4);
    create(10, 32'h0000_A000);
    add(10, 0, 0, 1);
    get("R8 freed dependence gives no edge");
    create(1, 32'h0000_BEEF);
    add(1, 0, 1, 1);
    get("R2 R4 reused id waits on reader");
    fin(10);
    get("R2 reused id fresh descriptor");
    fin(6); fin(7); fin(9); fin(1);
    get("R9 empty at end");

    @(negedge clk);
    check("R9 one pulse per get", rsp_seen == gets, rsp_seen, gets);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule